// File: doc/BRIEF.md
# PN Matched-Filter Correlator

This block is the despreading filter at the front of a direct-sequence spread-spectrum receiver. Signed samples arrive one per clock. Each accepted sample moves down a tapped delay line that spans one 15-chip pseudo-noise period. Each tap carries a fixed weight of plus or minus one, so the filter needs no multiplier. A minus-one tap inverts the bits of its sample. A single correction constant, equal to the number of minus-one taps, is fed into the adder tree as one extra leaf. That constant turns the inverted values back into exact negations.

The adder tree has a register after every level, and each level is one bit wider than the one before. The root holds the full correlation value, which a threshold stage turns into a symbol decision: plus one, minus one, or no decision. A valid flag travels with the data. It is raised only for samples that complete a full window of 15 accepted samples, so the start-up transient never produces a result.

Top module: `pn_match_filter`

## Requirements
- R1: A sample enters the window only on a clock where `smp_vld_i` is high. On other clocks the window keeps its contents and the ingress register does not shift.
- R2: `sum_o` is the sum over j = 0..14 of w_j · x_j. Here x_0 is the newest accepted sample and x_j is the sample accepted j samples earlier. The weight w_j is +1 when bit j of the pattern 15'b100111010011011 is 1, and -1 when it is 0. Bit 14, the first chip of the sequence, weights the oldest sample.
- R3: The sum is exact for every combination of 8-bit inputs, including -128 and +127 on every tap. It stays within ±1920, which fits the 12-bit two's-complement `sum_o`.
- R4: A sample presented with `smp_vld_i` high before clock edge e gives `sum_vld_o` high, with its `sum_o`, after edge e+4. That is five register stages: the ingress register plus four tree levels.
- R5: After reset, the first 14 accepted samples produce no `sum_vld_o` pulse. The 15th accepted sample, and every accepted sample after it, produces exactly one pulse.
- R6: `dec_vld_o` rises one clock after a valid `sum_o`. The decision is +1, encoded as `dec_hit_o`=1 and `dec_sym_o`=1, when the sum is greater than or equal to the threshold (signed compare).
- R7: If the sum is not at or above the threshold but is at or below the negated threshold, the decision is -1, encoded as `dec_hit_o`=1 and `dec_sym_o`=0. In all other cases `dec_hit_o` and `dec_sym_o` are both 0. When the threshold is zero or negative, the +1 test takes priority. Both flags are 0 whenever `dec_vld_o` is 0.
- R8: `thresh_i` is captured in a register every clock. A decision formed at edge e uses the `thresh_i` value captured at edge e-1.
- R9: A synchronous `rst` clears the window, the fill count, the pipeline and all valid flags. After reset, every output is 0 and the 14-sample fill rule of R5 applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 8 | Two's-complement input sample |
| smp_vld_i | input | 1 | Sample qualifier; shifts the window |
| thresh_i | input | 12 | Signed decision threshold |
| sum_o | output | 12 | Two's-complement correlation value |
| sum_vld_o | output | 1 | `sum_o` holds a full-window result |
| dec_vld_o | output | 1 | A decision slot is present |
| dec_hit_o | output | 1 | A decision was made |
| dec_sym_o | output | 1 | Decided symbol: 1 for +1, 0 for -1 |

## Verification
The latency property assumes that `smp_vld_i` is a defined value on every clock. The decision properties assume that `thresh_i` is held or changed only on clock boundaries, since they compare against the value captured two clocks earlier. The stimulus drives every input on the falling edge and never leaves one undefined. It changes the threshold at random while data is flowing, so the one-clock capture delay of R8 is exercised. It also covers gaps in `smp_vld_i`, full-scale extremes in both polarities, and aligned peak patterns.

// File: rtl/pnmf_pkg.sv
package pnmf_pkg;

    // Encoded symbol decision: hit = a decision was made, sym = 1 for +1
    typedef struct packed {
        logic hit;
        logic sym;
    } dec_t;

    // Number of taps whose weight is -1 (pattern bit = 0)
    function automatic int count_neg(input int taps, input logic [63:0] pat);
        int n;
        n = 0;
        for (int j = 0; j < taps; j++) begin
            if (!pat[j]) n++;
        end
        return n;
    endfunction

    // Bit offset of tree level l inside the flat node vector
    function automatic int lvl_off(input int sw, input int levels, input int l);
        int o;
        o = 0;
        for (int k = 1; k < l; k++) begin
            o += (2 ** (levels - k)) * (sw + k);
        end
        return o;
    endfunction

endpackage

// File: rtl/pnmf_chain.sv
module pnmf_chain #(
    parameter int SW = 8,
    parameter int TAPS = 15,
    parameter logic [TAPS-1:0] PATTERN = 15'b100111010011011,
    parameter int NLEAF = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SW-1:0]         smp_i,
    input  logic                  vld_i,
    output logic [NLEAF*SW-1:0]   leaves_o,
    output logic                  vld_o
);
    localparam int CW  = $clog2(TAPS + 1);
    localparam int NEG = pnmf_pkg::count_neg(TAPS, 64'(PATTERN));

    typedef struct packed {
        logic [TAPS-1:0][SW-1:0] tap;
        logic [CW-1:0]           fill;
        logic                    vld;
    } chain_t;

    chain_t s_d, s_q;

    // Window shifts only on qualified samples; fill saturates at TAPS
    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (vld_i) begin
            s_d.tap = {s_q.tap[TAPS-2:0], smp_i};
            if (s_q.fill != CW'(TAPS)) begin
                s_d.fill = s_q.fill + 1'b1;
            end
            if (s_q.fill >= CW'(TAPS - 1)) begin
                s_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Leaf j < TAPS: tap j, inverted for a -1 weight.
    // Leaf TAPS: correction constant. Remaining leaves: zero.
    for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
        if (j < TAPS) begin : g_tap
            if (PATTERN[j]) begin : g_pos
                assign leaves_o[j*SW +: SW] = s_q.tap[j];
            end else begin : g_neg
                assign leaves_o[j*SW +: SW] = ~s_q.tap[j];
            end
        end else if (j == TAPS) begin : g_fix
            assign leaves_o[j*SW +: SW] = SW'(NEG);
        end else begin : g_pad
            assign leaves_o[j*SW +: SW] = '0;
        end
    end

    assign vld_o = s_q.vld;

endmodule

// File: rtl/pnmf_tree.sv
module pnmf_tree #(
    parameter int SW = 8,
    parameter int LEVELS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [(2**LEVELS)*SW-1:0]   leaves_i,
    input  logic                        vld_i,
    output logic [SW+LEVELS-1:0]        sum_o,
    output logic                        vld_o
);
    localparam int OW       = SW + LEVELS;
    localparam int TOT      = pnmf_pkg::lvl_off(SW, LEVELS, LEVELS + 1);
    localparam int ROOT_OFF = pnmf_pkg::lvl_off(SW, LEVELS, LEVELS);

    logic [TOT-1:0]    node_d, node_q;
    logic [LEVELS-1:0] vld_d, vld_q;

    // Level l holds 2**(LEVELS-l) nodes of SW+l bits; each adds two
    // sign-extended children from the level below.
    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        localparam int W    = SW + l;
        localparam int N    = 2 ** (LEVELS - l);
        localparam int OFF  = pnmf_pkg::lvl_off(SW, LEVELS, l);
        localparam int POFF = pnmf_pkg::lvl_off(SW, LEVELS, l - 1);
        for (genvar i = 0; i < N; i++) begin : g_node
            logic [W-2:0] op_a, op_b;
            if (l == 1) begin : g_from_leaf
                assign op_a = leaves_i[(2*i)*SW +: SW];
                assign op_b = leaves_i[(2*i+1)*SW +: SW];
            end else begin : g_from_node
                assign op_a = node_q[POFF + (2*i)*(W-1) +: W-1];
                assign op_b = node_q[POFF + (2*i+1)*(W-1) +: W-1];
            end
            assign node_d[OFF + i*W +: W] = {op_a[W-2], op_a} + {op_b[W-2], op_b};
        end
    end

    always_comb begin
        vld_d = LEVELS'({vld_q, vld_i});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            node_q <= '0;
            vld_q  <= '0;
        end else begin
            node_q <= node_d;
            vld_q  <= vld_d;
        end
    end

    assign sum_o = node_q[ROOT_OFF +: OW];
    assign vld_o = vld_q[LEVELS-1];

endmodule

// File: rtl/pnmf_detect.sv
module pnmf_detect #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sum_i,
    input  logic         vld_i,
    input  logic [W-1:0] thr_i,
    output logic         vld_o,
    output logic         hit_o,
    output logic         sym_o
);
    typedef struct packed {
        logic [W-1:0]     thr;
        logic             vld;
        pnmf_pkg::dec_t   dec;
    } det_t;

    det_t s_d, s_q;
    logic signed [W:0] sum_x, thr_x, thr_n;

    // Compare one bit wider so negating the most negative threshold is safe
    always_comb begin
        sum_x   = signed'({sum_i[W-1], sum_i});
        thr_x   = signed'({s_q.thr[W-1], s_q.thr});
        thr_n   = -thr_x;
        s_d     = s_q;
        s_d.thr = thr_i;
        s_d.vld = vld_i;
        s_d.dec = '0;
        if (vld_i) begin
            if (sum_x >= thr_x) begin
                s_d.dec = '{hit: 1'b1, sym: 1'b1};
            end else if (sum_x <= thr_n) begin
                s_d.dec = '{hit: 1'b1, sym: 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o = s_q.vld;
    assign hit_o = s_q.dec.hit;
    assign sym_o = s_q.dec.sym;

endmodule

// File: rtl/pn_match_filter.sv
module pn_match_filter #(
    parameter int SW = 8,
    parameter int TAPS = 15,
    parameter logic [TAPS-1:0] PATTERN = 15'b100111010011011
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [SW-1:0]                   smp_i,
    input  logic                            smp_vld_i,
    input  logic [SW+$clog2(TAPS+1)-1:0]    thresh_i,
    output logic [SW+$clog2(TAPS+1)-1:0]    sum_o,
    output logic                            sum_vld_o,
    output logic                            dec_vld_o,
    output logic                            dec_hit_o,
    output logic                            dec_sym_o
);
    localparam int LEVELS = $clog2(TAPS + 1);
    localparam int NLEAF  = 2 ** LEVELS;
    localparam int OW     = SW + LEVELS;

    logic [NLEAF*SW-1:0] leaves;
    logic                win_vld;
    logic [OW-1:0]       tree_sum;
    logic                tree_vld;

    pnmf_chain #(
        .SW(SW), .TAPS(TAPS), .PATTERN(PATTERN), .NLEAF(NLEAF)
    ) u_chain (
        .clk(clk), .rst(rst), .smp_i(smp_i), .vld_i(smp_vld_i),
        .leaves_o(leaves), .vld_o(win_vld)
    );

    pnmf_tree #(
        .SW(SW), .LEVELS(LEVELS)
    ) u_tree (
        .clk(clk), .rst(rst), .leaves_i(leaves), .vld_i(win_vld),
        .sum_o(tree_sum), .vld_o(tree_vld)
    );

    pnmf_detect #(
        .W(OW)
    ) u_detect (
        .clk(clk), .rst(rst), .sum_i(tree_sum), .vld_i(tree_vld),
        .thr_i(thresh_i), .vld_o(dec_vld_o), .hit_o(dec_hit_o),
        .sym_o(dec_sym_o)
    );

    assign sum_o     = tree_sum;
    assign sum_vld_o = tree_vld;

endmodule

// File: rtl/pn_match_filter_chk.sv
module pn_match_filter_chk #(
    parameter int SW = 8,
    parameter int TAPS = 15
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         smp_vld_i,
    input logic [SW+$clog2(TAPS+1)-1:0] thresh_i,
    input logic [SW+$clog2(TAPS+1)-1:0] sum_o,
    input logic                         sum_vld_o,
    input logic                         dec_vld_o,
    input logic                         dec_hit_o,
    input logic                         dec_sym_o
);
    localparam int LAT   = $clog2(TAPS + 1) + 1;
    localparam int BOUND = TAPS * (2 ** (SW - 1));

    // R4: a valid result traces back to a qualified sample LAT clocks earlier
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        sum_vld_o |-> $past(smp_vld_i, LAT));

    // R3: full-window sums stay inside the exact range
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        sum_vld_o |-> ($signed(sum_o) <= BOUND && $signed(sum_o) >= -BOUND));

    // R6: decision slot follows a valid sum by one clock
    a_r6_dec_after_sum: assert property (@(posedge clk) disable iff (rst)
        dec_vld_o |-> $past(sum_vld_o));

    // R6 with R8: a +1 decision means the sum reached the captured threshold
    a_r6_pos_rule: assert property (@(posedge clk) disable iff (rst)
        (dec_vld_o && dec_sym_o) |-> ($signed($past(sum_o)) >= $signed($past(thresh_i, 2))));

    // R7: no decision only when the sum was below the threshold
    a_r7_none_below: assert property (@(posedge clk) disable iff (rst)
        (dec_vld_o && !dec_hit_o) |-> ($signed($past(sum_o)) < $signed($past(thresh_i, 2))));

    // R7: flags quiet in empty slots, symbol only with a hit
    a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !dec_vld_o |-> (!dec_hit_o && !dec_sym_o));

    a_r7_sym_needs_hit: assert property (@(posedge clk) disable iff (rst)
        dec_sym_o |-> dec_hit_o);

endmodule

bind pn_match_filter pn_match_filter_chk #(.SW(SW), .TAPS(TAPS)) u_chk (
    .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .thresh_i(thresh_i),
    .sum_o(sum_o), .sum_vld_o(sum_vld_o), .dec_vld_o(dec_vld_o),
    .dec_hit_o(dec_hit_o), .dec_sym_o(dec_sym_o)
);

// File: tb/pn_match_filter_bench.sv
module pn_match_filter_bench;
    localparam int TAPS = 15;
    localparam logic [14:0] PAT = 15'b100111010011011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  smp = '0;
    logic        smp_vld = 1'b0;
    logic [11:0] thr = '0;
    logic [11:0] sum_o;
    logic        sum_vld_o, dec_vld_o, dec_hit_o, dec_sym_o;

    pn_match_filter u_pn_match_filter (
        .clk(clk), .rst(rst), .smp_i(smp), .smp_vld_i(smp_vld),
        .thresh_i(thr), .sum_o(sum_o), .sum_vld_o(sum_vld_o),
        .dec_vld_o(dec_vld_o), .dec_hit_o(dec_hit_o), .dec_sym_o(dec_sym_o)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    fill = 0;
    int    seen = 0;
    int    win [TAPS];
    int    r_sum [8];
    bit    r_vld [8];
    int    r_thr [8];
    string tag_s = "R2";
    string tag_v = "R4";
    string tag_d = "";
    bit    finished = 1'b0;

    function automatic int wsum();
        int s = 0;
        for (int j = 0; j < TAPS; j++) s += PAT[j] ? win[j] : -win[j];
        return s;
    endfunction

    function automatic logic [1:0] exp_dec(int s, int t);
        if (s >= t) return 2'b11;
        if (s <= -t) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock: compare outputs against the model, then drive the next input
    task automatic step(int x, bit v, int t, bit r);
        int i5, i6, i2, k;
        logic [1:0] ed;
        string td;
        @(negedge clk);
        i5 = (cyc + 3) % 8;
        i6 = (cyc + 2) % 8;
        i2 = (cyc + 6) % 8;
        if (sum_vld_o) seen++;
        chk(sum_vld_o == r_vld[i5], tag_v, "sum_vld", int'(sum_vld_o), int'(r_vld[i5]));
        if (r_vld[i5])
            chk($signed(sum_o) == r_sum[i5], tag_s, "sum", $signed(sum_o), r_sum[i5]);
        ed = r_vld[i6] ? exp_dec(r_sum[i6], r_thr[i2]) : 2'b00;
        chk(dec_vld_o == r_vld[i6], "R6", "dec_vld", int'(dec_vld_o), int'(r_vld[i6]));
        td = (tag_d != "") ? tag_d : ((ed == 2'b11) ? "R6" : "R7");
        chk({dec_hit_o, dec_sym_o} == ed, td, "decision", int'({dec_hit_o, dec_sym_o}), int'(ed));

        rst = r; smp = x[7:0]; smp_vld = v; thr = t[11:0];
        k = cyc % 8;
        r_thr[k] = t;
        if (r) begin
            fill = 0;
            for (int j = 0; j < 8; j++) r_vld[j] = 1'b0;
        end else if (v) begin
            for (int j = TAPS - 1; j > 0; j--) win[j] = win[j-1];
            win[0] = x;
            if (fill < TAPS) fill++;
            r_vld[k] = (fill >= TAPS);
            r_sum[k] = wsum();
        end else begin
            r_vld[k] = 1'b0;
        end
        cyc++;
    endtask

    task automatic idle(int n, int t);
        for (int i = 0; i < n; i++) step(0, 1'b0, t, 1'b0);
    endtask

    function automatic int rnd_smp();
        return int'($urandom % 256) - 128;
    endfunction

    initial begin
        void'($urandom(32'd20251));
        for (int j = 0; j < TAPS; j++) win[j] = 0;
        for (int j = 0; j < 8; j++) begin r_vld[j] = 1'b0; r_sum[j] = 0; r_thr[j] = 0; end

        // R9: reset state
        for (int i = 0; i < 3; i++) step(0, 1'b0, 1000, 1'b1);
        chk(sum_o == 12'd0 && !sum_vld_o && !dec_vld_o && !dec_hit_o && !dec_sym_o,
            "R9", "reset outputs", int'(sum_o), 0);

        // R5: 14 samples fill without a result, the 15th gives one
        tag_v = "R5";
        seen = 0;
        for (int i = 0; i < 14; i++) step(rnd_smp(), 1'b1, 1000, 1'b0);
        idle(8, 1000);
        chk(seen == 0, "R5", "pulses during fill", seen, 0);
        step(rnd_smp(), 1'b1, 1000, 1'b0);
        idle(7, 1000);
        chk(seen == 1, "R5", "pulses after 15th sample", seen, 1);
        tag_v = "R4";

        // R6 / R7: aligned peaks, oldest chip first
        for (int k = 14; k >= 0; k--) step(PAT[k] ? 100 : -100, 1'b1, 1000, 1'b0);
        for (int k = 14; k >= 0; k--) step(PAT[k] ? -100 : 100, 1'b1, 1000, 1'b0);
        idle(8, 1000);

        // R3: full-scale extremes
        tag_s = "R3";
        for (int i = 0; i < 20; i++) step(-128, 1'b1, 1000, 1'b0);
        for (int i = 0; i < 20; i++) step(127, 1'b1, 1000, 1'b0);
        for (int k = 14; k >= 0; k--) step(PAT[k] ? 127 : -128, 1'b1, 1000, 1'b0);
        for (int k = 14; k >= 0; k--) step(PAT[k] ? -128 : 127, 1'b1, 1000, 1'b0);
        idle(8, 1000);
        tag_s = "R2";

        // R1 / R8: gaps in the qualifier, threshold changing while streaming
        begin
            int t = 200;
            tag_s = "R1";
            tag_d = "R8";
            for (int i = 0; i < 3000; i++) begin
                if ($urandom % 16 == 0) t = int'($urandom % 900) - 300;
                step(rnd_smp(), ($urandom % 4) != 0, t, 1'b0);
            end
            idle(8, t);
            tag_s = "R2";
            tag_d = "";
        end

        // R7: zero and negative thresholds, +1 has priority
        tag_d = "R7";
        for (int i = 0; i < 200; i++) step(rnd_smp(), 1'b1, 0, 1'b0);
        for (int i = 0; i < 200; i++) step(rnd_smp(), 1'b1, -200, 1'b0);
        idle(8, -200);
        tag_d = "";

        // R9: reset in mid-stream, then refill
        for (int i = 0; i < 20; i++) step(rnd_smp(), 1'b1, 150, 1'b0);
        step(0, 1'b0, 150, 1'b1);
        step(rnd_smp(), 1'b1, 150, 1'b0);
        chk(sum_o == 12'd0 && !sum_vld_o && !dec_vld_o, "R9", "mid-stream reset", int'(sum_o), 0);
        tag_v = "R9";
        seen = 0;
        for (int i = 0; i < 13; i++) step(rnd_smp(), 1'b1, 150, 1'b0);
        idle(8, 150);
        chk(seen == 0, "R9", "pulses during refill", seen, 0);
        for (int i = 0; i < 30; i++) step(rnd_smp(), 1'b1, 150, 1'b0);
        idle(8, 150);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule